// File: doc/BRIEF.md
# Channel Configuration Write Guard

This block stands in front of the register port of an eight-channel load driver. It inspects each configuration write before the write goes out. It keeps a shadow copy of the state that decides legality: the channel-enable bits, the mode field of each channel pair, and the drive type and side select of every channel. It also synchronises two external trigger levels. If a request is legal, the block forwards it unchanged one clock later. If it is not legal, the block drops the request and reports a code that names the violated rule. The shadow copy changes only when a write is forwarded.

Register selection is on a small target address. Target 0 is the status register. The eight channel-enable bits sit in its top byte, and the four two-bit pair-mode fields sit in bits [15:8], with pair p at bits [8+2p+1:8+2p]. Targets 1 to 8 are the configuration registers of channels 0 to 7. In those registers, bit 7 selects current drive (1) or voltage drive (0), bit 6 selects high side (1) or low side (0), and bits [5:3] are three low-side-only options. A narrow write carries a single byte in the top byte position.

Top module: `cfg_write_guard`

## Requirements
- R1: While reset is high and after it is released, both result strobes are low and the reject code is 0. The shadow then holds all channels off, all pair modes 0, and all channels set to voltage drive on the low side.
- R2: Each valid request gives exactly one result on the following clock. A legal request appears on the forward port with its target, data and narrow flag unchanged, and the reject strobe stays low.
- R3: A channel configuration with both current drive (bit 7) and high side (bit 6) set is rejected with code 1.
- R4: A channel configuration that selects high side and sets any option bit [5:3] is rejected with code 2.
- R5: A channel configuration that changes bit 7 or bit 6 relative to the shadow is rejected with code 3 when any channel-enable bit is set.
- R6: A channel configuration that changes bit 7 or bit 6 is rejected with code 4 while either trigger input (after two synchroniser stages) is high. A configuration that leaves both bits unchanged is not affected by triggers or enables.
- R7: A full status write that changes the mode field of a pair is rejected with code 5 when either channel of that pair is enabled. Pairs are channels (0,1), (2,3), (4,5) and (6,7). Changing the mode of a pair whose channels are both off is legal.
- R8: A narrow status write is always accepted. It updates only the channel-enable bits, and the pair-mode shadow is kept.
- R9: A rejected request never reaches the forward port and leaves the shadow unchanged.
- R10: A request whose target is above 8 is rejected with code 6.
- R11: When several rules fail, the lowest code is reported: 1, then 2, then 3, then 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | ADDR_W | Target register (0 status, 1..NUM_CH channel config) |
| req_data | input | DATA_W | Proposed register value |
| req_narrow | input | 1 | Single top-byte write |
| trig_a | input | 1 | External trigger level A (asynchronous) |
| trig_b | input | 1 | External trigger level B (asynchronous) |
| out_valid | output | 1 | Forwarded write strobe |
| out_addr | output | ADDR_W | Forwarded target |
| out_data | output | DATA_W | Forwarded value |
| out_narrow | output | 1 | Forwarded narrow flag |
| rej_valid | output | 1 | Rejection strobe |
| rej_code | output | 3 | Violated rule code (0 when none) |

## Verification
Each of the 32 settings of the five checked configuration bits is written to every channel. This is repeated under four enable patterns (none, a low channel, a high channel, a middle group) and all four trigger combinations. The runs separate the side/type conflicts from the enable and trigger freezes, and they exercise the priority among them. A second sweep walks enable bytes against pair-mode bytes in full status writes. It shows that only a pair with a live channel blocks a mode change. Narrow status writes with junk in the lower bits are interleaved, so a leak into the pair shadow would surface on later writes. Out-of-range targets close the run.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
  typedef enum logic [2:0] {
    REJ_NONE      = 3'd0,
    REJ_CUR_HIGH  = 3'd1,
    REJ_OPT_HIGH  = 3'd2,
    REJ_CH_ON     = 3'd3,
    REJ_TRIG      = 3'd4,
    REJ_PAIR_BUSY = 3'd5,
    REJ_BAD_ADDR  = 3'd6
  } rej_code_e;

  localparam int CFG_DRV_BIT  = 7;
  localparam int CFG_SIDE_BIT = 6;
  localparam int CFG_OPT_LSB  = 3;
  localparam int CFG_OPT_W    = 3;
  localparam int PAIR_LSB     = 8;
endpackage

// File: rtl/wguard_trig_sync.sv
module wguard_trig_sync #(
  parameter int NUM_IN = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] din,
  output logic [NUM_IN-1:0] dout
);
  logic [NUM_IN-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= din;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wguard_shadow.sv
module wguard_shadow
  import wguard_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_narrow,
  output logic [NUM_CH-1:0] on_q,
  output logic [NUM_CH-1:0] pair_q,
  output logic [NUM_CH-1:0] drv_q,
  output logic [NUM_CH-1:0] side_q
);
  localparam int ON_LSB = DATA_W - NUM_CH;

  logic is_status;
  assign is_status = (req_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= '0;
      pair_q <= '0;
    end else if (apply && is_status) begin
      on_q <= req_data[ON_LSB +: NUM_CH];
      if (!req_narrow) pair_q <= req_data[PAIR_LSB +: NUM_CH];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        drv_q[c]  <= 1'b0;
        side_q[c] <= 1'b0;
      end else if (apply && req_addr == ADDR_W'(c + 1)) begin
        drv_q[c]  <= req_data[CFG_DRV_BIT];
        side_q[c] <= req_data[CFG_SIDE_BIT];
      end
    end
  end

  assert_narrow_keeps_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (apply && is_status && req_narrow) |=> $stable(pair_q));

  assert_mode_frozen_when_on_R5: assert property (@(posedge clk) disable iff (rst)
    (apply && !is_status && (|on_q)) |=> ($stable(drv_q) && $stable(side_q)));
endmodule

// File: rtl/wguard_rules.sv
module wguard_rules
  import wguard_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_narrow,
  input  logic [NUM_CH-1:0] on_q,
  input  logic [NUM_CH-1:0] pair_q,
  input  logic [NUM_CH-1:0] drv_q,
  input  logic [NUM_CH-1:0] side_q,
  input  logic              trig_any,
  output rej_code_e         code
);
  localparam int NPAIR = NUM_CH / 2;
  localparam int CH_W  = $clog2(NUM_CH);

  logic [NPAIR-1:0] pair_block;
  logic             is_status, is_cfg;
  logic [CH_W-1:0]  ch_idx;
  logic             new_drv, new_side, mode_chg;
  logic [CFG_OPT_W-1:0] new_opt;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_block[p] = (req_data[PAIR_LSB + 2*p +: 2] != pair_q[2*p +: 2]) &&
                           (on_q[2*p] || on_q[2*p+1]);
  end

  assign is_status = (req_addr == '0);
  assign is_cfg    = (req_addr >= ADDR_W'(1)) && (req_addr <= ADDR_W'(NUM_CH));
  assign ch_idx    = CH_W'(req_addr - ADDR_W'(1));
  assign new_drv   = req_data[CFG_DRV_BIT];
  assign new_side  = req_data[CFG_SIDE_BIT];
  assign new_opt   = req_data[CFG_OPT_LSB +: CFG_OPT_W];
  assign mode_chg  = (new_drv != drv_q[ch_idx]) || (new_side != side_q[ch_idx]);

  always_comb begin
    code = REJ_NONE;
    if (is_status) begin
      if (!req_narrow && (|pair_block)) code = REJ_PAIR_BUSY;
    end else if (is_cfg) begin
      if (new_drv && new_side)             code = REJ_CUR_HIGH;
      else if (new_side && (|new_opt))     code = REJ_OPT_HIGH;
      else if (mode_chg && (|on_q))        code = REJ_CH_ON;
      else if (mode_chg && trig_any)       code = REJ_TRIG;
    end else begin
      code = REJ_BAD_ADDR;
    end
  end
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import wguard_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_narrow,
  input  logic              trig_a,
  input  logic              trig_b,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_narrow,
  output logic              rej_valid,
  output logic [2:0]        rej_code
);
  logic [1:0]        trig_s;
  logic [NUM_CH-1:0] on_q, pair_q, drv_q, side_q;
  rej_code_e         code;
  logic              apply;

  wguard_trig_sync #(.NUM_IN(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({trig_b, trig_a}), .dout(trig_s)
  );

  assign apply = req_valid && (code == REJ_NONE);

  wguard_shadow #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst(rst), .apply(apply), .req_addr(req_addr), .req_data(req_data),
    .req_narrow(req_narrow), .on_q(on_q), .pair_q(pair_q), .drv_q(drv_q), .side_q(side_q)
  );

  wguard_rules #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rules (
    .req_addr(req_addr), .req_data(req_data), .req_narrow(req_narrow),
    .on_q(on_q), .pair_q(pair_q), .drv_q(drv_q), .side_q(side_q),
    .trig_any(|trig_s), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_data   <= '0;
      out_narrow <= 1'b0;
      rej_valid  <= 1'b0;
      rej_code   <= 3'd0;
    end else begin
      out_valid  <= apply;
      out_addr   <= req_addr;
      out_data   <= req_data;
      out_narrow <= req_narrow;
      rej_valid  <= req_valid && (code != REJ_NONE);
      rej_code   <= req_valid ? code : REJ_NONE;
    end
  end

  logic out_is_cfg;
  assign out_is_cfg = (out_addr >= ADDR_W'(1)) && (out_addr <= ADDR_W'(NUM_CH));

  assert_one_result_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (out_valid || rej_valid));

  assert_never_both_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && rej_valid));

  assert_fwd_no_cur_high_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_cfg) |-> !(out_data[CFG_DRV_BIT] && out_data[CFG_SIDE_BIT]));

  assert_fwd_no_opt_high_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_cfg && out_data[CFG_SIDE_BIT]) |->
      (out_data[CFG_OPT_LSB +: CFG_OPT_W] == '0));

  assert_code_range_R10: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_code != 3'd0 && rej_code <= 3'd6));
endmodule

// File: tb/cfg_write_guard_tb_top.sv
module cfg_write_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_narrow = 1'b0;
  logic        trig_a = 1'b0, trig_b = 1'b0;
  logic        out_valid, out_narrow, rej_valid;
  logic [3:0]  out_addr;
  logic [31:0] out_data;
  logic [2:0]  rej_code;

  int n_chk = 0, n_bad = 0;

  logic [7:0] m_on = '0, m_pair = '0, m_drv = '0, m_side = '0;
  logic       m_trig = 1'b0;

  always #2 clk = ~clk;

  cfg_write_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_narrow(req_narrow), .trig_a(trig_a), .trig_b(trig_b),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
    .out_narrow(out_narrow), .rej_valid(rej_valid), .rej_code(rej_code)
  );

  function automatic int exp_code(input logic [3:0] a, input logic [31:0] d, input logic n);
    if (a == 4'd0) begin
      if (n) return 0;
      for (int p = 0; p < 4; p++)
        if (d[8+2*p +: 2] != m_pair[2*p +: 2] && (m_on[2*p] || m_on[2*p+1])) return 5;
      return 0;
    end else if (a <= 4'd8) begin
      int c;
      logic chg;
      c = int'(a) - 1;
      chg = (d[7] != m_drv[c]) || (d[6] != m_side[c]);
      if (d[7] && d[6]) return 1;
      if (d[6] && (|d[5:3])) return 2;
      if (chg && (|m_on)) return 3;
      if (chg && m_trig) return 4;
      return 0;
    end
    return 6;
  endfunction

  function automatic string req_tag(input int code, input logic n);
    case (code)
      0: return n ? "R8" : "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic do_req(input logic [3:0] a, input logic [31:0] d, input logic n);
    int e;
    e = exp_code(a, d, n);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_narrow = n;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    // R9: a rejected request must show out_valid low
    if (out_valid !== (e == 0) || rej_valid !== (e != 0) || rej_code !== 3'(e) ||
        (e == 0 && (out_addr !== a || out_data !== d || out_narrow !== n))) begin
      n_bad++;
      $display("FAIL %s addr=%0d data=%h narrow=%0d: got fwd=%0d rej=%0d code=%0d data=%h, exp fwd=%0d rej=%0d code=%0d data=%h",
               req_tag(e, n), a, d, n, out_valid, rej_valid, rej_code, out_data,
               (e == 0), (e != 0), e, d);
    end
    if (e == 0) begin
      if (a == 4'd0) begin
        m_on = d[31:24];
        if (!n) m_pair = d[15:8];
      end else begin
        m_drv[int'(a)-1]  = d[7];
        m_side[int'(a)-1] = d[6];
      end
    end
  endtask

  task automatic set_trig(input logic a, input logic b);
    @(negedge clk);
    trig_a = a; trig_b = b;
    repeat (3) @(negedge clk);
    m_trig = a | b;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got running, exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'h3C;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || rej_valid !== 1'b0 || rej_code !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 during reset: got fwd=%0d rej=%0d code=%0d, exp 0 0 0", out_valid, rej_valid, rej_code);
    end
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || rej_valid !== 1'b0 || rej_code !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 after reset: got fwd=%0d rej=%0d code=%0d, exp 0 0 0", out_valid, rej_valid, rej_code);
    end
    // R1: reset shadow is voltage/low-side, so an all-zero config passes even with triggers high
    set_trig(1'b1, 1'b0);
    do_req(4'd1, 32'h0000_0000, 1'b0);
    do_req(4'd8, 32'h0000_0038, 1'b0);
    // R11: every rule broken at once reports code 1
    do_req(4'd0, 32'hFF00_0000, 1'b1);
    do_req(4'd3, 32'h0000_00F8, 1'b0);
    do_req(4'd3, 32'h0000_0078, 1'b0);
    do_req(4'd3, 32'h0000_0080, 1'b0);
    do_req(4'd0, 32'h0000_0000, 1'b1);

    // Configuration sweep: R3 R4 R5 R6 R11
    for (int t = 0; t < 4; t++) begin
      set_trig(t[0], t[1]);
      for (int o = 0; o < 4; o++) begin
        do_req(4'd0, {pats[o], 24'hA5A5A5}, 1'b1);
        for (int ch = 1; ch <= 8; ch++)
          for (int v = 0; v < 32; v++)
            do_req(4'(ch), {8'(ch * v), 16'h0, 5'(v), 3'b101}, 1'b0);
      end
    end

    // Pair-mode sweep: R7, with narrow writes for R8
    set_trig(1'b0, 1'b0);
    for (int o = 0; o < 256; o += 3) begin
      for (int p = 0; p < 256; p += 7)
        do_req(4'd0, {8'(o), 8'h5A, 8'(p), 8'hC3}, 1'b0);
      do_req(4'd0, {8'(o) ^ 8'hFF, 24'h123456}, 1'b1);
    end

    // Out-of-range targets: R10
    for (int a = 9; a < 16; a++) do_req(4'(a), 32'h0000_0000, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule